// File: doc/BRIEF.md
# LDPC Encoder Input Framer

This block sits in front of a quasi-cyclic LDPC encoder core. It takes message beats on a 384-bit bus, marked by a valid strobe and a start-of-packet strobe. On the first beat of a frame it samples a 12-bit mode word and decodes it into four values: the lifting size Z, the base graph, the number of message beats Kb and the code rate. It then passes each message beat downstream, with every bit at or above position Z forced to zero.

Base graph 2 messages can be shorter than ten beats. For these, the framer appends whole zero beats so that the core always sees ten systematic beats. Base graph 1 frames carry 22 beats and get no filler. The output stream has its own valid, start and end strobes, and the decoded parameters are held beside it. A mode word that is illegal is flagged and its frame is discarded. A new start that arrives in the middle of a message cancels the unfinished frame and raises a separate error pulse.

Top module: `ldpc_enc_framer`

## Requirements
- R1: While reset is low and on the first cycle after it, out_valid, out_sop, out_eop, mode_err and abort_err are 0 and in_ready is 1.
- R2: Mode bits [5:0] select Z. Codes 0..14 give 2..16 in steps of 1. Codes 15..22 give 18..32 in steps of 2. Codes 23..30 give 36..64 in steps of 4. Codes 31..38 give 72..128 in steps of 8. Codes 39..46 give 144..256 in steps of 16. Codes 47..50 give 288..384 in steps of 32. Codes 51..63 are illegal. The decoded Z appears on out_z with the start beat.
- R3: Mode bits [11:9] select the graph. 000 is base graph 1 with Kb=22 (out_bg2=0). 001, 011, 101 and 111 are base graph 2 with Kb of 6, 8, 9 and 10 (out_bg2=1). All other codes are illegal.
- R4: Mode bits [8:6] give the rate code, which appears unchanged on out_rate. Rate 000 is illegal with base graph 1. Rates 101, 110 and 111 are illegal with base graph 2.
- R5: An illegal mode raises mode_err for one cycle, one cycle after its start beat. That frame then produces no output beats.
- R6: Each output beat carries the input bits below Z unchanged, and every bit at or above Z is 0, whatever the input holds there.
- R7: An accepted beat appears on the output one cycle after it is accepted. out_sop marks the first beat of the frame, and there is exactly one output beat per accepted message beat.
- R8: For base graph 2 with Kb below 10, the message is followed by 10−Kb all-zero beats on consecutive cycles. During those cycles in_ready is 0 and the inputs, start strobe included, are ignored.
- R9: out_eop is high on exactly one beat per frame: the 10th systematic beat for base graph 2, or the 22nd for base graph 1.
- R10: A start beat that arrives before the current frame has all Kb beats raises abort_err for one cycle. The new frame then begins with that beat.
- R11: A valid beat without start-of-packet is ignored while no frame is open.
- R12: out_z, out_bg2, out_kb and out_rate stay constant from the start beat until the next accepted start beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a frame; the mode word is sampled with it |
| in_mode | input | 12 | Mode word: Z code, rate code, graph/Kb code |
| in_data | input | 384 | Message beat, Z low bits meaningful |
| in_ready | output | 1 | Low while filler beats are being generated |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First systematic beat |
| out_eop | output | 1 | Last systematic beat |
| out_data | output | 384 | Masked message beat or zero filler |
| out_z | output | 9 | Decoded lifting size |
| out_bg2 | output | 1 | 1 for base graph 2 |
| out_kb | output | 5 | Decoded message beat count |
| out_rate | output | 3 | Rate code of the current frame |
| mode_err | output | 1 | One-cycle pulse on an illegal mode |
| abort_err | output | 1 | One-cycle pulse when an open frame is cut short |

## Verification
If the beat counter drifts or the sequencer sits in the wrong state, the first thing to go wrong is the end strobe. It lands on a beat other than the 10th or 22nd, and this is seen one cycle after the beat that should have closed the frame. If the filler phase is entered wrongly, in_ready drops while message beats are still due, or the zero beats come too few or too many. Either shows up within ten cycles of the last message beat. A wrong lifting-size register lets nonzero bits appear above out_z on the very next beat. A mis-decoded mode shows at the start beat, either on out_z and out_kb or as an error pulse that does not belong there.

// File: rtl/ldpc_fr_pkg.sv
// Package: shared constants, types and the lifting-size decode for the
// encoder input framer. Assumes the mode word layout {graph[2:0], rate[2:0], zcode[5:0]}.
package ldpc_fr_pkg;

    localparam int MODE_W    = 12;
    localparam int KB_W      = 5;
    localparam int SYS_BEATS = 10;
    localparam int BG1_KB    = 22;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_FILL = 2'd2
    } seq_state_t;

    // Lifting-size code to Z: codes below 15 step by one from 2, then
    // groups of eight that start at 18 and double every group.
    function automatic int unsigned z_of_code(input logic [5:0] code);
        int unsigned c;
        int unsigned grp;
        int unsigned ofs;
        c = int'(code);
        if (c < 15) begin
            return c + 2;
        end
        grp = (c - 15) / 8;
        ofs = (c - 15) % 8;
        return (18 + 2 * ofs) << grp;
    endfunction

endpackage

// File: rtl/ldpc_fr_mode_dec.sv
// Mode decoder: turns the 12-bit mode word into Z, graph, Kb and rate,
// and judges legality. Purely combinational; assumes ZW is wide enough
// to hold 384.
module ldpc_fr_mode_dec
    import ldpc_fr_pkg::*;
#(
    parameter int ZW = 9
) (
    input  logic [MODE_W-1:0] mode,
    output logic [ZW-1:0]     z,
    output logic              bg2,
    output logic [KB_W-1:0]   kb,
    output logic [2:0]        rate,
    output logic              legal
);

    logic [5:0] zcode;
    logic [2:0] gcode;
    logic       z_ok;
    logic       g_ok;
    logic       r_ok;

    assign zcode = mode[5:0];
    assign rate  = mode[8:6];
    assign gcode = mode[11:9];

    // Lifting size lookup and its legal range.
    always_comb begin
        z    = ZW'(z_of_code(zcode));
        z_ok = (zcode <= 6'd50);
    end

    // Graph / message-length decode.
    always_comb begin
        bg2  = 1'b1;
        kb   = KB_W'(SYS_BEATS);
        g_ok = 1'b1;
        case (gcode)
            3'b000:  begin bg2 = 1'b0; kb = KB_W'(BG1_KB); end
            3'b001:  kb = KB_W'(6);
            3'b011:  kb = KB_W'(8);
            3'b101:  kb = KB_W'(9);
            3'b111:  kb = KB_W'(10);
            default: g_ok = 1'b0;
        endcase
    end

    // Rate legality depends on the graph.
    always_comb begin
        if (bg2) begin
            r_ok = (rate < 3'd5);
        end else begin
            r_ok = (rate != 3'd0);
        end
    end

    assign legal = z_ok && g_ok && r_ok;

endmodule

// File: rtl/ldpc_fr_mask.sv
// Beat masker: clears every bus bit at or above the lifting size.
// Combinational; assumes z <= DATA_W.
module ldpc_fr_mask #(
    parameter int DATA_W = 384,
    parameter int ZW     = 9
) (
    input  logic [ZW-1:0]     z,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int CW = ZW + 1;

    // One comparator per bit position.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign dout[b] = din[b] & ({1'b0, z} > CW'(b));
    end

endmodule

// File: rtl/ldpc_fr_seq.sv
// Frame sequencer: opens frames on start beats, counts message beats,
// generates zero filler up to the fixed systematic length, and drives
// the registered output stream and error pulses. Assumes Kb >= 2.
module ldpc_fr_seq
    import ldpc_fr_pkg::*;
#(
    parameter int DATA_W = 384,
    parameter int ZW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [ZW-1:0]     dec_z,
    input  logic              dec_bg2,
    input  logic [KB_W-1:0]   dec_kb,
    input  logic [2:0]        dec_rate,
    input  logic              dec_legal,
    input  logic [DATA_W-1:0] beat_masked,
    output logic              take_sop,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic [ZW-1:0]     cur_z,
    output logic              cur_bg2,
    output logic [KB_W-1:0]   cur_kb,
    output logic [2:0]        cur_rate,
    output logic              mode_err,
    output logic              abort_err
);

    seq_state_t      state;
    logic [KB_W-1:0] cnt;
    logic [KB_W-1:0] cnt_nx;

    // Handshake and start detection.
    assign in_ready = (state != ST_FILL);
    assign take_sop = in_valid && in_sop && in_ready;
    assign cnt_nx   = cnt + KB_W'(1);

    // State, counter, parameter hold and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cur_z     <= '0;
            cur_bg2   <= 1'b0;
            cur_kb    <= '0;
            cur_rate  <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
            mode_err  <= 1'b0;
            abort_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
            mode_err  <= 1'b0;
            abort_err <= 1'b0;
            if (state == ST_FILL) begin
                out_valid <= 1'b1;
                cnt       <= cnt_nx;
                if (cnt_nx == KB_W'(SYS_BEATS)) begin
                    out_eop <= 1'b1;
                    state   <= ST_IDLE;
                end
            end else if (take_sop) begin
                abort_err <= (state == ST_MSG);
                if (!dec_legal) begin
                    mode_err <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    cur_z     <= dec_z;
                    cur_bg2   <= dec_bg2;
                    cur_kb    <= dec_kb;
                    cur_rate  <= dec_rate;
                    out_valid <= 1'b1;
                    out_sop   <= 1'b1;
                    out_data  <= beat_masked;
                    cnt       <= KB_W'(1);
                    state     <= ST_MSG;
                end
            end else if (state == ST_MSG && in_valid) begin
                out_valid <= 1'b1;
                out_data  <= beat_masked;
                cnt       <= cnt_nx;
                if (cnt_nx == cur_kb) begin
                    if (cur_kb < KB_W'(SYS_BEATS)) begin
                        state <= ST_FILL;
                    end else begin
                        out_eop <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ldpc_enc_framer.sv
// Top: LDPC encoder input framer. Decodes the mode word on start beats,
// masks each beat to Z bits and emits a fixed-length systematic stream.
// Assumes DATA_W is at least the largest lifting size (384).
module ldpc_enc_framer #(
    parameter int DATA_W = 384,
    parameter int ZW     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [11:0]       in_mode,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic [ZW-1:0]     out_z,
    output logic              out_bg2,
    output logic [4:0]        out_kb,
    output logic [2:0]        out_rate,
    output logic              mode_err,
    output logic              abort_err
);

    logic [ZW-1:0]     dec_z;
    logic              dec_bg2;
    logic [4:0]        dec_kb;
    logic [2:0]        dec_rate;
    logic              dec_legal;
    logic              take_sop;
    logic [ZW-1:0]     mask_z;
    logic [DATA_W-1:0] beat_masked;

    ldpc_fr_mode_dec #(.ZW(ZW)) u_dec (
        .mode  (in_mode),
        .z     (dec_z),
        .bg2   (dec_bg2),
        .kb    (dec_kb),
        .rate  (dec_rate),
        .legal (dec_legal)
    );

    // The start beat is masked with its own fresh Z, later beats with the held one.
    assign mask_z = take_sop ? dec_z : out_z;

    ldpc_fr_mask #(.DATA_W(DATA_W), .ZW(ZW)) u_mask (
        .z    (mask_z),
        .din  (in_data),
        .dout (beat_masked)
    );

    ldpc_fr_seq #(.DATA_W(DATA_W), .ZW(ZW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .dec_z       (dec_z),
        .dec_bg2     (dec_bg2),
        .dec_kb      (dec_kb),
        .dec_rate    (dec_rate),
        .dec_legal   (dec_legal),
        .beat_masked (beat_masked),
        .take_sop    (take_sop),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .out_data    (out_data),
        .cur_z       (out_z),
        .cur_bg2     (out_bg2),
        .cur_kb      (out_kb),
        .cur_rate    (out_rate),
        .mode_err    (mode_err),
        .abort_err   (abort_err)
    );

endmodule

// File: rtl/ldpc_enc_framer_chk.sv
// Checker: temporal properties of the framer output stream, bound into
// every instance of the top module.
module ldpc_enc_framer_chk #(
    parameter int DATA_W = 384,
    parameter int ZW     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_sop,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_data,
    input logic [ZW-1:0]     out_z,
    input logic              out_bg2,
    input logic              mode_err
);

    logic [4:0] beats_seen;
    logic [4:0] beat_no;

    // Count systematic beats since the last start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_seen <= '0;
        end else if (out_valid) begin
            beats_seen <= beat_no;
        end
    end

    assign beat_no = out_sop ? 5'd1 : beats_seen + 5'd1;

    // R7
    sop_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    // R9
    eop_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid);

    // R6
    high_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> out_z) == '0));

    // R9
    eop_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> (beat_no == (out_bg2 ? 5'd10 : 5'd22)));

    // R8
    fill_streams_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (out_valid && !out_sop && (out_data == '0)));

    // R5
    bad_mode_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !out_valid);

    // R12
    params_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> $stable(out_z));

endmodule

bind ldpc_enc_framer ldpc_enc_framer_chk #(.DATA_W(DATA_W), .ZW(ZW)) u_chk (.*);

// File: tb/ldpc_enc_framer_tb.sv
`timescale 1ns/1ps
module ldpc_enc_framer_tb;

    localparam int DW = 384;
    localparam int ZW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic [11:0]   in_mode = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_sop;
    logic          out_eop;
    logic [DW-1:0] out_data;
    logic [ZW-1:0] out_z;
    logic          out_bg2;
    logic [4:0]    out_kb;
    logic [2:0]    out_rate;
    logic          mode_err;
    logic          abort_err;

    always #2.5 clk = ~clk;

    ldpc_enc_framer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_mode(in_mode), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data), .out_z(out_z), .out_bg2(out_bg2),
        .out_kb(out_kb), .out_rate(out_rate), .mode_err(mode_err),
        .abort_err(abort_err)
    );

    // Vector: {mode[11:0], legal, bg2, kb[4:0], z[8:0]}
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {3'b000, 3'b001, 6'd30, 1'b1, 1'b0, 5'd22, 9'd64},
        {3'b001, 3'b000, 6'd0,  1'b1, 1'b1, 5'd6,  9'd2},
        {3'b011, 3'b100, 6'd50, 1'b1, 1'b1, 5'd8,  9'd384},
        {3'b101, 3'b011, 6'd15, 1'b1, 1'b1, 5'd9,  9'd18},
        {3'b111, 3'b010, 6'd39, 1'b1, 1'b1, 5'd10, 9'd144},
        {3'b000, 3'b111, 6'd47, 1'b1, 1'b0, 5'd22, 9'd288},
        {3'b000, 3'b000, 6'd5,  1'b0, 1'b0, 5'd22, 9'd7},
        {3'b001, 3'b101, 6'd5,  1'b0, 1'b1, 5'd6,  9'd7},
        {3'b010, 3'b001, 6'd5,  1'b0, 1'b1, 5'd6,  9'd7},
        {3'b000, 3'b001, 6'd51, 1'b0, 1'b0, 5'd22, 9'd0}
    };

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Per-run observations gathered by the monitor.
    int n_beats, n_sop, n_eop, n_merr, n_aerr, n_bad, n_badz, n_rdy_low, idx;
    int exp_z = 0;
    int exp_kb = 0;

    function automatic logic [DW-1:0] zmask(input int z);
        logic [DW-1:0] m;
        for (int b = 0; b < DW; b++) m[b] = (b < z);
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        n_beats = 0; n_sop = 0; n_eop = 0; n_merr = 0; n_aerr = 0;
        n_bad = 0; n_badz = 0; n_rdy_low = 0; idx = 0;
    endtask

    // Monitor: samples outputs between edges.
    always @(negedge clk) begin : mon
        int k;
        if (rst_n) begin
            if (!in_ready) n_rdy_low++;
            if (mode_err) n_merr++;
            if (abort_err) n_aerr++;
            if (out_valid) begin
                k = out_sop ? 0 : idx;
                if (out_data !== ((k < exp_kb) ? zmask(exp_z) : '0)) n_bad++;
                if (out_sop && int'(out_z) != exp_z) n_badz++;
                if (out_sop) n_sop++;
                if (out_eop) n_eop++;
                idx = k + 1;
                n_beats++;
            end
        end
    end

    task automatic drive_beat(input bit sop, input logic [11:0] mode);
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = sop;
        in_mode  = mode;
        in_data  = '1;
    endtask

    task automatic drive_idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] m;
        bit lg;
        bit bg;
        int kb;
        int z;
        int total;
        clear_obs();
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!out_valid && !out_sop && !out_eop && !mode_err && !abort_err, "R1",
              "outputs in reset", out_valid, 0);
        check(in_ready, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !mode_err && !abort_err && in_ready, "R1",
              "state after reset", out_valid, 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R12
        for (int v = 0; v < NV; v++) begin
            m  = VEC[v][27:16];
            lg = VEC[v][15];
            bg = VEC[v][14];
            kb = int'(VEC[v][13:9]);
            z  = int'(VEC[v][8:0]);
            exp_z = z; exp_kb = kb;
            clear_obs();
            for (int i = 0; i < kb; i++) drive_beat(i == 0, m);
            drive_idle(14);
            if (lg) begin
                total = bg ? 10 : 22;
                check(n_beats == total, "R8", $sformatf("beats v%0d", v), n_beats, total);
                check(n_sop == 1 && n_badz == 0, "R2", $sformatf("sop/Z v%0d", v), n_badz, 0);
                check(out_kb == 5'(kb) && out_bg2 == bg, "R3",
                      $sformatf("kb v%0d", v), out_kb, kb);
                check(out_rate == m[8:6], "R4", $sformatf("rate v%0d", v), out_rate, m[8:6]);
                check(n_bad == 0, "R6", $sformatf("data v%0d", v), n_bad, 0);
                check(n_eop == 1, "R9", $sformatf("eop v%0d", v), n_eop, 1);
                check(n_rdy_low == total - kb, "R8", $sformatf("ready low v%0d", v),
                      n_rdy_low, total - kb);
                check(n_merr == 0, "R4", $sformatf("no err v%0d", v), n_merr, 0);
            end else begin
                check(n_merr == 1, "R5", $sformatf("mode_err v%0d", v), n_merr, 1);
                check(n_beats == 0, "R5", $sformatf("dropped v%0d", v), n_beats, 0);
            end
        end

        // R11: beats without start while idle
        clear_obs();
        for (int i = 0; i < 4; i++) drive_beat(1'b0, {3'b000, 3'b001, 6'd30});
        drive_idle(4);
        check(n_beats == 0, "R11", "idle beats ignored", n_beats, 0);

        // R10: abort an open frame, new frame completes
        clear_obs();
        exp_z = 64; exp_kb = 6;
        for (int i = 0; i < 3; i++) drive_beat(i == 0, {3'b000, 3'b001, 6'd30});
        for (int i = 0; i < 6; i++) drive_beat(i == 0, {3'b001, 3'b011, 6'd30});
        drive_idle(14);
        check(n_aerr == 1, "R10", "abort pulse", n_aerr, 1);
        check(n_beats == 13 && n_sop == 2, "R10", "abort beats", n_beats, 13);
        check(n_eop == 1 && out_bg2 && out_kb == 5'd6, "R10", "new frame", n_eop, 1);

        // R8 + R12: start beats during filler are ignored
        clear_obs();
        exp_z = 2; exp_kb = 6;
        for (int i = 0; i < 6; i++) drive_beat(i == 0, {3'b001, 3'b000, 6'd0});
        for (int i = 0; i < 4; i++) drive_beat(1'b1, {3'b000, 3'b001, 6'd50});
        drive_idle(14);
        check(n_beats == 10 && n_sop == 1, "R8", "sop in filler ignored", n_beats, 10);
        check(out_z == 9'd2 && n_aerr == 0, "R12", "params held", out_z, 2);
        check(n_bad == 0, "R6", "filler zero", n_bad, 0);

        // R1: reset in mid-frame
        clear_obs();
        drive_beat(1'b1, {3'b000, 3'b001, 6'd30});
        drive_beat(1'b0, {3'b000, 3'b001, 6'd30});
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!out_valid && in_ready && !out_eop, "R1", "mid-frame reset", out_valid, 0);
        drive_idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule